// File: doc/BRIEF.md
# Memory Traffic Generator and Checker

This block exercises a memory through a simple request/ready port with a 16-bit data word. Once started, it sweeps an ascending run of addresses, first writing generated data and then reading it back. It regenerates the same data locally and compares every returned word against it. Passes repeat until a stop command arrives. The operating mode decides whether each iteration writes and then reads, only reads, or only writes.

Three data sources are available: a 15-bit pseudo-random sequence, a 16-entry stored pattern selected by the low address bits, and an arithmetic ramp that changes with every iteration. While a test is running, an inject request corrupts exactly one future word, so the read check must catch it. Two error counters, one for detected errors and one for injected errors, can be cleared together. Separate counters record the bytes written and the bytes read.

Read data is combinational with respect to the request: `mem_rdata_i` must be valid in the same cycle that `mem_req_o && mem_ready_i` accepts a read.

Top module: `mem_traffic_gen`

## Requirements
- R1: After reset, `state_o` is 0 (idle), `mem_req_o` is low, and all four counters read zero.
- R2: `start_i` in idle begins a run. The first pass is a write pass (`state_o`=1), or a read pass (`state_o`=2) in read-only mode, and it begins at address 0. `stop_i` while running returns `state_o` to 0 at the next clock edge, and requests cease. `start_i` while running is ignored.
- R3: Each pass issues addresses 0 to N-1 in ascending order, advancing by one per accepted word, then wraps to 0. N is `addr_count_i` captured at start and clamped to the range 2 to 524288.
- R4: `mode_i` selects the pass order. Value 0 (and 3) alternates write and read passes. Value 1 repeats read passes. Value 2 repeats write passes. An iteration counter starts at 0 and increments after each complete iteration: a read pass in modes 0 and 1, a write pass in mode 2.
- R5: With `src_i`=0, the word is {q[0], q[14:0]}. The 15-bit register q is loaded with 1 at the start of every pass and steps to {q[13:0], q[14]^q[13]} on every accepted word.
- R6: With `src_i`=1, the word at address a is {k, ~k, k, ~k}, where k = a[3:0].
- R7: With `src_i`=2 or 3, the word at address a is (3·a + iteration) modulo 65536.
- R8: Every accepted read whose data differs from the expected word increments `det_err_o` by exactly one.
- R9: Each `inject_i` cycle while running queues one corruption, with up to 15 outstanding. The next word written has its bit 0 inverted; in read-only mode, the next expected word has its bit 0 inverted instead. `inj_err_o` increments when that word is accepted.
- R10: `inject_i` while idle has no effect on `inj_err_o` or on later traffic.
- R11: `clear_i` zeroes `det_err_o` and `inj_err_o` at the next edge and takes priority over any increment in the same cycle.
- R12: `wr_bytes_o` and `rd_bytes_o` increase by 2 for each accepted write or read word, and both reset to zero when a run starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run (idle only) |
| stop_i | input | 1 | Abort the run |
| mode_i | input | 2 | 0 write-then-read, 1 read-only, 2 write-only |
| src_i | input | 2 | 0 pseudo-random, 1 stored pattern, 2/3 arithmetic |
| addr_count_i | input | 20 | Addresses per pass |
| inject_i | input | 1 | Request one corrupted word |
| clear_i | input | 1 | Zero both error counters |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 19 | Word address |
| mem_wdata_o | output | 16 | Write data |
| mem_ready_i | input | 1 | Memory accepts the request this cycle |
| mem_rdata_i | input | 16 | Read data, valid when a read is accepted |
| state_o | output | 2 | 0 idle, 1 write pass, 2 read pass |
| det_err_o | output | 32 | Detected mismatches |
| inj_err_o | output | 32 | Injected corruptions |
| wr_bytes_o | output | 32 | Bytes written |
| rd_bytes_o | output | 32 | Bytes read |

## Verification
The hardest case is an injected error that must reach the read side as exactly one detected error. An inject can arrive during a read pass of write-then-read mode, in which case the corruption has to wait for the next write pass and then survive until the matching read. The bench pulses inject mid-run, and also twice back to back, with the ready signal stalling one cycle in four. It lets at least one full iteration elapse and then requires the detected and injected counts to be equal. Read-only mode is reached by pre-filling memory with a write-only run of the stored pattern, so that the only possible mismatch is the injected one.

// File: rtl/mtg_pkg.sv
`timescale 1ns/1ps
package mtg_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_WR = 2'd1, ST_RD = 2'd2} state_e;
  localparam logic [1:0] MODE_WTR = 2'd0;
  localparam logic [1:0] MODE_RO  = 2'd1;
  localparam logic [1:0] MODE_WO  = 2'd2;
  localparam logic [1:0] SRC_PRBS = 2'd0;
  localparam logic [1:0] SRC_TAB  = 2'd1;
  localparam logic [14:0] PRBS_SEED = 15'h0001;
endpackage

// File: rtl/mtg_pattern.sv
`timescale 1ns/1ps
module mtg_pattern import mtg_pkg::*; #(
  parameter int DW = 16,
  parameter int AW = 19
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    src_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] iter_i,
  input  logic          restart_i,
  input  logic          advance_i,
  output logic [DW-1:0] data_o
);
  localparam int TAB_N = 16;

  logic [14:0]   lfsr_q;
  logic [DW-1:0] tab [TAB_N];
  logic [DW-1:0] math_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        lfsr_q <= PRBS_SEED;
    else if (restart_i) lfsr_q <= PRBS_SEED;
    else if (advance_i) lfsr_q <= {lfsr_q[13:0], lfsr_q[14] ^ lfsr_q[13]};
  end

  for (genvar k = 0; k < TAB_N; k++) begin : g_tab
    localparam logic [3:0] K = 4'(k);
    assign tab[k] = DW'({K, ~K, K, ~K});
  end

  assign math_w = DW'(DW'(addr_i) * DW'(3)) + iter_i;

  always_comb begin
    case (src_i)
      SRC_PRBS: data_o = DW'({lfsr_q[0], lfsr_q});
      SRC_TAB:  data_o = tab[addr_i[3:0]];
      default:  data_o = math_w;
    endcase
  end
endmodule

// File: rtl/mtg_counters.sv
`timescale 1ns/1ps
module mtg_counters #(
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          start_i,
  input  logic          det_i,
  input  logic          inj_i,
  input  logic          wr_i,
  input  logic          rd_i,
  output logic [CW-1:0] det_o,
  output logic [CW-1:0] inj_o,
  output logic [CW-1:0] wr_o,
  output logic [CW-1:0] rd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      det_o <= '0;
      inj_o <= '0;
    end else if (clear_i) begin
      det_o <= '0;
      inj_o <= '0;
    end else begin
      if (det_i) det_o <= det_o + CW'(1);
      if (inj_i) inj_o <= inj_o + CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_o <= '0;
      rd_o <= '0;
    end else if (start_i) begin
      wr_o <= '0;
      rd_o <= '0;
    end else begin
      if (wr_i) wr_o <= wr_o + CW'(2);
      if (rd_i) rd_o <= rd_o + CW'(2);
    end
  end
endmodule

// File: rtl/mem_traffic_gen.sv
`timescale 1ns/1ps
module mem_traffic_gen import mtg_pkg::*; #(
  parameter int DW      = 16,
  parameter int CW      = 32,
  parameter int MIN_CNT = 2,
  parameter int MAX_CNT = 524288,
  parameter int PEND_W  = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           start_i,
  input  logic                           stop_i,
  input  logic [1:0]                     mode_i,
  input  logic [1:0]                     src_i,
  input  logic [$clog2(MAX_CNT+1)-1:0]   addr_count_i,
  input  logic                           inject_i,
  input  logic                           clear_i,
  output logic                           mem_req_o,
  output logic                           mem_we_o,
  output logic [$clog2(MAX_CNT)-1:0]     mem_addr_o,
  output logic [DW-1:0]                  mem_wdata_o,
  input  logic                           mem_ready_i,
  input  logic [DW-1:0]                  mem_rdata_i,
  output logic [1:0]                     state_o,
  output logic [CW-1:0]                  det_err_o,
  output logic [CW-1:0]                  inj_err_o,
  output logic [CW-1:0]                  wr_bytes_o,
  output logic [CW-1:0]                  rd_bytes_o
);
  localparam int AW = $clog2(MAX_CNT);
  localparam int NW = $clog2(MAX_CNT + 1);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  state_e            state_q;
  logic [1:0]        mode_q, src_q, mode_n;
  logic [NW-1:0]     cnt_q, cnt_eff;
  logic [AW-1:0]     addr_q;
  logic [DW-1:0]     iter_q, pat, expect_w, mask;
  logic [PEND_W-1:0] pend_q;
  logic running, is_wr, acc, last, go, pass_end, iter_end, inj_here, mismatch, inj_done, pend_inc;

  assign mode_n   = (mode_i == 2'd3) ? MODE_WTR : mode_i;
  assign cnt_eff  = (addr_count_i < NW'(MIN_CNT)) ? NW'(MIN_CNT) :
                    (addr_count_i > NW'(MAX_CNT)) ? NW'(MAX_CNT) : addr_count_i;
  assign running  = (state_q != ST_IDLE);
  assign is_wr    = (state_q == ST_WR);
  assign go       = !running && start_i;
  assign acc      = running && mem_ready_i;
  assign last     = (NW'(addr_q) == cnt_q - NW'(1));
  assign pass_end = acc && last;
  assign iter_end = pass_end && (mode_q != MODE_WTR || !is_wr);
  assign inj_here = running && (pend_q != '0) && (is_wr || mode_q == MODE_RO);
  assign mask     = {{(DW-1){1'b0}}, inj_here};
  assign expect_w = pat ^ mask;
  assign mismatch = acc && !is_wr && (mem_rdata_i != expect_w);
  assign inj_done = acc && inj_here;
  assign pend_inc = inject_i && (pend_q != PEND_MAX);

  mtg_pattern #(.DW(DW), .AW(AW)) u_pat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .src_i     (src_q),
    .addr_i    (addr_q),
    .iter_i    (iter_q),
    .restart_i (go || pass_end),
    .advance_i (acc),
    .data_o    (pat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_WTR;
      src_q   <= SRC_PRBS;
      cnt_q   <= NW'(MIN_CNT);
      addr_q  <= '0;
      iter_q  <= '0;
    end else if (go) begin
      state_q <= (mode_n == MODE_RO) ? ST_RD : ST_WR;
      mode_q  <= mode_n;
      src_q   <= src_i;
      cnt_q   <= cnt_eff;
      addr_q  <= '0;
      iter_q  <= '0;
    end else if (running) begin
      if (stop_i) begin
        state_q <= ST_IDLE;
      end else if (acc) begin
        if (last) begin
          addr_q <= '0;
          if (iter_end) iter_q <= iter_q + DW'(1);
          if (mode_q == MODE_WTR) state_q <= is_wr ? ST_RD : ST_WR;
        end else begin
          addr_q <= addr_q + AW'(1);
        end
      end
    end
  end

  // outstanding corruptions; dropped when the run ends
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pend_q <= '0;
    else if (!running || stop_i) pend_q <= '0;
    else pend_q <= pend_q + PEND_W'(pend_inc) - PEND_W'(inj_done);
  end

  mtg_counters #(.CW(CW)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .start_i (go),
    .det_i   (mismatch),
    .inj_i   (inj_done),
    .wr_i    (acc && is_wr),
    .rd_i    (acc && !is_wr),
    .det_o   (det_err_o),
    .inj_o   (inj_err_o),
    .wr_o    (wr_bytes_o),
    .rd_o    (rd_bytes_o)
  );

  assign mem_req_o   = running;
  assign mem_we_o    = is_wr;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = is_wr ? expect_w : '0;
  assign state_o     = state_q;
endmodule

// File: rtl/mtg_chk.sv
`timescale 1ns/1ps
module mtg_chk #(
  parameter int AW = 19,
  parameter int NW = 20,
  parameter int CW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          stop_i,
  input logic          clear_i,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic          mem_ready_i,
  input logic [AW-1:0] mem_addr_o,
  input logic [1:0]    state_o,
  input logic [CW-1:0] det_err_o,
  input logic [CW-1:0] inj_err_o,
  input logic [CW-1:0] wr_bytes_o,
  input logic [CW-1:0] rd_bytes_o,
  input logic [NW-1:0] cnt_q
);
  // R2
  stop_to_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && stop_i) |=> (state_o == 2'd0 && !mem_req_o));
  // R3
  addr_in_span_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (NW'(mem_addr_o) < cnt_q));
  // R3
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ready_i && !stop_i && (NW'(mem_addr_o) != cnt_q - NW'(1)))
      |=> (mem_addr_o == $past(mem_addr_o) + AW'(1)));
  // R8
  det_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> ((det_err_o - $past(det_err_o)) <= CW'(1)));
  // R10
  idle_inject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_req_o && !clear_i) |=> $stable(inj_err_o));
  // R11
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (det_err_o == '0 && inj_err_o == '0));
  // R12
  wr_bytes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && mem_ready_i) |=> (wr_bytes_o == $past(wr_bytes_o) + CW'(2)));
  // R12
  rd_bytes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o && mem_ready_i) |=> (rd_bytes_o == $past(rd_bytes_o) + CW'(2)));
endmodule

bind mem_traffic_gen mtg_chk #(.AW(AW), .NW(NW), .CW(CW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .stop_i      (stop_i),
  .clear_i     (clear_i),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_ready_i (mem_ready_i),
  .mem_addr_o  (mem_addr_o),
  .state_o     (state_o),
  .det_err_o   (det_err_o),
  .inj_err_o   (inj_err_o),
  .wr_bytes_o  (wr_bytes_o),
  .rd_bytes_o  (rd_bytes_o),
  .cnt_q       (cnt_q)
);

// File: tb/mem_traffic_gen_tb_top.sv
`timescale 1ns/1ps
module mem_traffic_gen_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 0, stop_i = 0, inject_i = 0, clear_i = 0;
  logic [1:0] mode_i = 0, src_i = 0;
  logic [19:0] addr_count_i = 20'd8;
  logic mem_req_o, mem_we_o, mem_ready_i;
  logic [18:0] mem_addr_o;
  logic [15:0] mem_wdata_o, mem_rdata_i;
  logic [1:0] state_o;
  logic [31:0] det_err_o, inj_err_o, wr_bytes_o, rd_bytes_o;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [15:0] mem [64];
  logic [31:0] cyc = 0;
  bit data_en = 1;
  int m_mode, m_src, m_n, e_addr, e_iter, acc_wr, acc_rd;
  bit e_wr;

  always #2.5 clk_i = ~clk_i;

  mem_traffic_gen dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
    .mode_i(mode_i), .src_i(src_i), .addr_count_i(addr_count_i),
    .inject_i(inject_i), .clear_i(clear_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i),
    .state_o(state_o), .det_err_o(det_err_o), .inj_err_o(inj_err_o),
    .wr_bytes_o(wr_bytes_o), .rd_bytes_o(rd_bytes_o)
  );

  assign mem_rdata_i = mem[mem_addr_o[5:0]];

  // ready stalls one cycle in four
  always_ff @(posedge clk_i) begin
    cyc <= cyc + 1;
    mem_ready_i <= (cyc[1:0] != 2'b11);
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input int s, input int a, input int it);
    logic [14:0] q;
    logic [3:0] k;
    if (s == 0) begin
      q = 15'h0001;
      for (int i = 0; i < a; i++) q = {q[13:0], q[14] ^ q[13]};
      return {q[0], q};
    end else if (s == 1) begin
      k = 4'(a);
      return {k, ~k, k, ~k};
    end
    return 16'(a * 3 + it);
  endfunction

  always @(negedge clk_i) begin
    if (rst_ni && mem_req_o && mem_ready_i) begin
      if (mem_we_o) mem[mem_addr_o[5:0]] = mem_wdata_o;
      check(int'(mem_addr_o) == e_addr, "R3 address order", mem_addr_o, e_addr);
      check(mem_we_o == e_wr, "R4 pass direction", mem_we_o, e_wr);
      if (mem_we_o) begin
        acc_wr++;
        if (data_en)
          check(mem_wdata_o == exp_word(m_src, e_addr, e_iter),
                (m_src == 0) ? "R5 prbs data" : (m_src == 1) ? "R6 table data" : "R7 math data",
                mem_wdata_o, exp_word(m_src, e_addr, e_iter));
      end else acc_rd++;
      if (e_addr == m_n - 1) begin
        e_addr = 0;
        if (m_mode == 0) begin
          if (!e_wr) e_iter++;
          e_wr = !e_wr;
        end else e_iter++;
      end else e_addr++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic start_run(input int md, input int s, input int n_in);
    @(negedge clk_i);
    m_mode = md; m_src = s;
    m_n = (n_in < 2) ? 2 : n_in;
    e_addr = 0; e_iter = 0; e_wr = (md != 1);
    acc_wr = 0; acc_rd = 0;
    mode_i = 2'(md); src_i = 2'(s); addr_count_i = 20'(n_in);
    start_i = 1;
    @(negedge clk_i);
    start_i = 0;
  endtask

  task automatic stop_run();
    @(negedge clk_i); stop_i = 1;
    @(negedge clk_i); stop_i = 0;
    check(state_o == 2'd0 && !mem_req_o, "R2 stop to idle", state_o, 0);
  endtask

  task automatic pulse_clear();
    @(negedge clk_i); clear_i = 1;
    @(negedge clk_i); clear_i = 0;
  endtask

  task automatic pulse_inject(input int n);
    @(negedge clk_i); inject_i = 1;
    tick(n); inject_i = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'h0;
    tick(3);
    // R1
    check(state_o == 0 && !mem_req_o, "R1 reset state", state_o, 0);
    check(det_err_o == 0 && inj_err_o == 0, "R1 error counters", det_err_o + inj_err_o, 0);
    check(wr_bytes_o == 0 && rd_bytes_o == 0, "R1 byte counters", wr_bytes_o + rd_bytes_o, 0);
    rst_ni = 1;
    tick(2);

    // R2 first pass state, R5 R6 R7 write-only sweeps, R12 write bytes
    for (int s = 0; s < 4; s++) begin
      start_run(2, s, 8);
      check(state_o == 2'd1, "R2 first pass is write", state_o, 1);
      tick(60);
      stop_run();
      check(acc_wr > 16, "R4 write-only repeats", acc_wr, 17);
      check(wr_bytes_o == 32'(2 * acc_wr), "R12 write bytes", wr_bytes_o, 2 * acc_wr);
      check(rd_bytes_o == 0, "R12 no reads in write-only", rd_bytes_o, 0);
    end

    // R4 R8 write-then-read for each source
    for (int s = 0; s < 3; s++) begin
      pulse_clear();
      start_run(0, s, 16);
      tick(200);
      stop_run();
      check(e_iter >= 2, "R4 iterations repeat", e_iter, 2);
      check(det_err_o == 0, "R8 clean readback", det_err_o, 0);
      check(rd_bytes_o == 32'(2 * acc_rd), "R12 read bytes", rd_bytes_o, 2 * acc_rd);
    end

    // R3 span boundaries: 2, and values below 2 clamp to 2
    foreach (addr_count_i[i]) ;
    for (int n = 0; n < 3; n++) begin
      start_run(2, 1, n);
      tick(20);
      stop_run();
      check(acc_wr > 4, "R3 two-word span wraps", acc_wr, 5);
    end
    start_run(2, 2, 40);
    tick(150);
    stop_run();
    check(e_iter >= 2, "R3 forty-word span wraps", e_iter, 2);

    // R10 inject while idle
    pulse_clear();
    pulse_inject(1);
    tick(3);
    check(inj_err_o == 0, "R10 idle inject ignored", inj_err_o, 0);
    data_en = 1;
    start_run(2, 1, 8);
    tick(30);
    stop_run();
    check(inj_err_o == 0, "R10 no late corruption", inj_err_o, 0);

    // R9 single inject in write-then-read
    data_en = 0;
    pulse_clear();
    start_run(0, 1, 8);
    tick(5);
    pulse_inject(1);
    tick(80);
    stop_run();
    check(inj_err_o == 1, "R9 one inject counted", inj_err_o, 1);
    check(det_err_o == 1, "R9 inject detected", det_err_o, 1);

    // R9 back-to-back injects
    pulse_clear();
    start_run(0, 1, 8);
    tick(5);
    pulse_inject(2);
    tick(80);
    stop_run();
    check(inj_err_o == 2, "R9 two injects counted", inj_err_o, 2);
    check(det_err_o == 2, "R9 two injects detected", det_err_o, 2);

    // R9 write-only: injected but never read
    pulse_clear();
    start_run(2, 1, 8);
    tick(4);
    pulse_inject(1);
    tick(20);
    stop_run();
    check(inj_err_o == 1 && det_err_o == 0, "R9 write-only inject", {inj_err_o, det_err_o}, 64'h1_0000_0000);

    // R9 read-only path after a clean prefill
    data_en = 1;
    start_run(2, 1, 8);
    tick(30);
    stop_run();
    pulse_clear();
    start_run(1, 1, 8);
    check(state_o == 2'd2, "R2 read-only starts reading", state_o, 2);
    tick(40);
    check(det_err_o == 0, "R8 read-only clean", det_err_o, 0);
    check(wr_bytes_o == 0, "R12 bytes reset at start", wr_bytes_o, 0);
    pulse_inject(1);
    tick(30);
    stop_run();
    check(det_err_o == 1 && inj_err_o == 1, "R9 read-only inject", {det_err_o, inj_err_o}, 64'h1_0000_0001);

    // R11 clear
    pulse_clear();
    check(det_err_o == 0 && inj_err_o == 0, "R11 clear", det_err_o + inj_err_o, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule